// File: doc/BRIEF.md
# Two-Bank Wide Register File

This block is the operand store for a datapath that runs very wide custom instructions. It holds 32 registers of 128 bits each, split into two banks of 16. One instruction can read three operands in the same cycle. It can also write back two results in one cycle, because each of the two write ports feeds its own bank.

A register address is 5 bits wide. The top bit picks the bank (0 = bank A, 1 = bank B) and the low 4 bits pick the entry inside that bank. Reads are combinational. Writes commit on the rising clock edge. A register that is both a source and the destination of one operation is therefore read with its old value.

When both write ports are enabled and their bank-select bits name the same bank, the request is illegal. The block raises a conflict flag for that cycle and drops the port-1 write.

Top module: `wrf_banked_top`

## Requirements
- R1: The file holds 32 registers of 128 bits. Address bit 4 selects the bank (0 = A, 1 = B), and bits 3:0 select the entry, so register n of bank B has address 16+n.
- R2: Three read ports return, combinationally and independently in the same cycle, the contents of the registers they address, including when two ports name the same register.
- R3: When wr_en0 is high, wr_data0 is written on the rising edge into bank A at entry wr_addr0[3:0]. Bit 4 of wr_addr0 does not change which bank is written.
- R4: When wr_en1 is high and there is no conflict, wr_data1 is written on the rising edge into bank B at entry wr_addr1[3:0]. Bit 4 of wr_addr1 does not change which bank is written.
- R5: With both enables high and different bank-select bits, both writes commit on the same edge.
- R6: A read port that addresses a register being written in the same cycle returns the old value. The new value is visible after that edge.
- R7: conflict is high, combinationally, exactly in a cycle where both write enables are high and wr_addr0[4] equals wr_addr1[4]. Otherwise it is low.
- R8: During a conflict the port-1 write is dropped, leaving every bank-B register unchanged, while the port-0 write still commits.
- R9: A low rst_n sampled on a rising edge clears all 32 registers to zero.
- R10: A register that is not written on an edge keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_addr | input | 3x5 | Read addresses, one 5-bit field per read port |
| rd_data | output | 3x128 | Read data, one 128-bit field per read port |
| wr_en0 | input | 1 | Write enable, port 0 (bank A) |
| wr_addr0 | input | 5 | Port-0 destination; bit 4 is the requested bank |
| wr_data0 | input | 128 | Port-0 write data |
| wr_en1 | input | 1 | Write enable, port 1 (bank B) |
| wr_addr1 | input | 5 | Port-1 destination; bit 4 is the requested bank |
| wr_data1 | input | 128 | Port-1 write data |
| conflict | output | 1 | Both writes name the same bank this cycle |

## Verification
Read data and the conflict flag are due in the same cycle as the inputs that cause them. The bench drives on the falling edge and samples one nanosecond later, well before the next rising edge. A write shows up zero cycles late for reads in its own cycle, which must still see the old value, and one edge later for reads in any later cycle. The bench therefore reads back only at the falling edge after the committing edge. A shadow model, updated from the requirements at each committing edge, supplies every expected register value, and all 32 registers are swept after each scenario.

// File: rtl/wrf_pkg.sv
// Package: shared types for the two-bank wide register file.
// Assumes a single bank-select bit at the top of each register address.
package wrf_pkg;
    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;
endpackage

// File: rtl/wrf_bank.sv
// Module: one bank of wide registers with a single write port and
// NUM_RD combinational read ports. Reads return pre-edge contents.
// Assumes DEPTH entries addressed by IDX_W bits; the reset is synchronous.
module wrf_bank #(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 16,
    parameter int NUM_RD = 3,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data
);

    logic [DEPTH-1:0][DATA_W-1:0] mem;

    // Storage: clear on reset, otherwise commit the enabled write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (we) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Read ports: one combinational lookup per port.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            rd_data[p] = mem[rd_idx[p]];
        end
    end

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem));

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/wrf_write_ctrl.sv
// Module: turns the two write requests into per-bank enables. Port 0
// always owns bank A and port 1 owns bank B. When both requests name
// the same bank, the flag is raised and the port-1 write is dropped.
// Assumes the bank-select bits come straight from the write addresses.
module wrf_write_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en0,
    input  logic wr_en1,
    input  logic bank_sel0,
    input  logic bank_sel1,
    output logic we_a,
    output logic we_b,
    output logic conflict
);

    // Same-bank detection and enable gating.
    always_comb begin
        conflict = wr_en0 && wr_en1 && (bank_sel0 == bank_sel1);
        we_a     = wr_en0;
        we_b     = wr_en1 && !conflict;
    end

    // R5
    dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en0 && wr_en1 && (bank_sel0 != bank_sel1)) |-> (we_a && we_b && !conflict));

    // R8
    drop_port1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (we_a && !we_b));

endmodule

// File: rtl/wrf_banked_top.sv
// Module: 32 x 128-bit register file in two banks, with three read
// ports and two bank-bound write ports. The address MSB selects the bank.
// Assumes the caller honours the one-write-per-bank rule; on a
// violation the conflict flag is raised and port 1 is dropped.
module wrf_banked_top
    import wrf_pkg::*;
#(
    parameter int DATA_W     = 128,
    parameter int BANK_DEPTH = 16,
    parameter int NUM_RD     = 3,
    localparam int IDX_W     = $clog2(BANK_DEPTH),
    localparam int ADDR_W    = IDX_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data,
    input  logic                           wr_en0,
    input  logic [ADDR_W-1:0]              wr_addr0,
    input  logic [DATA_W-1:0]              wr_data0,
    input  logic                           wr_en1,
    input  logic [ADDR_W-1:0]              wr_addr1,
    input  logic [DATA_W-1:0]              wr_data1,
    output logic                           conflict
);

    logic                           we_a;
    logic                           we_b;
    logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx;
    logic [NUM_RD-1:0][DATA_W-1:0]  a_rdata;
    logic [NUM_RD-1:0][DATA_W-1:0]  b_rdata;

    wrf_write_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en0    (wr_en0),
        .wr_en1    (wr_en1),
        .bank_sel0 (wr_addr0[ADDR_W-1]),
        .bank_sel1 (wr_addr1[ADDR_W-1]),
        .we_a      (we_a),
        .we_b      (we_b),
        .conflict  (conflict)
    );

    // Entry index per read port: low address bits, shared by both banks.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_idx
        always_comb begin
            rd_idx[p] = rd_addr[p][IDX_W-1:0];
        end
    end

    wrf_bank #(
        .DATA_W (DATA_W),
        .DEPTH  (BANK_DEPTH),
        .NUM_RD (NUM_RD)
    ) u_bank_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we_a),
        .wr_idx  (wr_addr0[IDX_W-1:0]),
        .wr_data (wr_data0),
        .rd_idx  (rd_idx),
        .rd_data (a_rdata)
    );

    wrf_bank #(
        .DATA_W (DATA_W),
        .DEPTH  (BANK_DEPTH),
        .NUM_RD (NUM_RD)
    ) u_bank_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we_b),
        .wr_idx  (wr_addr1[IDX_W-1:0]),
        .wr_data (wr_data1),
        .rd_idx  (rd_idx),
        .rd_data (b_rdata)
    );

    // Bank selection per read port, driven by the address MSB.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_sel
        always_comb begin
            if (bank_e'(rd_addr[p][ADDR_W-1]) == BANK_B) begin
                rd_data[p] = b_rdata[p];
            end else begin
                rd_data[p] = a_rdata[p];
            end
        end
    end

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));

endmodule

// File: tb/tb_wrf_banked_top.sv
// Directed bench: one task per scenario, each checking its own results
// against a shadow model updated from the requirements.
module tb_wrf_banked_top;

    localparam int DW = 128;
    localparam int AW = 5;
    localparam int NR = 3;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [NR-1:0][AW-1:0] rd_addr;
    logic [NR-1:0][DW-1:0] rd_data;
    logic                  wr_en0;
    logic [AW-1:0]         wr_addr0;
    logic [DW-1:0]         wr_data0;
    logic                  wr_en1;
    logic [AW-1:0]         wr_addr1;
    logic [DW-1:0]         wr_data1;
    logic                  conflict;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [DW-1:0] model [32];

    always #4 clk = ~clk;

    wrf_banked_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en0   (wr_en0),
        .wr_addr0 (wr_addr0),
        .wr_data0 (wr_data0),
        .wr_en1   (wr_en1),
        .wr_addr1 (wr_addr1),
        .wr_data1 (wr_data1),
        .conflict (conflict)
    );

    function automatic logic [DW-1:0] pat(int k, int s);
        logic [31:0] w;
        w = 32'(k) * 32'h01010101 ^ 32'(s) * 32'h5A5A0000 ^ 32'hC3000001;
        return {w, ~w, w ^ 32'h0F0F0F0F, w + 32'd7};
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en0 = 1'b0;
        wr_en1 = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 32; r++) model[r] = '0;
    endtask

    // One write cycle; conflict is checked in the same cycle (R7), and
    // the model follows R3, R4, R5 and R8 at the committing edge.
    task automatic do_write(input bit e0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                            input bit e1, input logic [AW-1:0] a1, input logic [DW-1:0] d1);
        logic exp_c;
        @(negedge clk);
        wr_en0 = e0; wr_addr0 = a0; wr_data0 = d0;
        wr_en1 = e1; wr_addr1 = a1; wr_data1 = d1;
        #1;
        exp_c = e0 && e1 && (a0[4] == a1[4]);
        check("R7 conflict flag", DW'(conflict), DW'(exp_c));
        @(posedge clk);
        if (e0) model[{1'b0, a0[3:0]}] = d0;
        if (e1 && !exp_c) model[{1'b1, a1[3:0]}] = d1;
        @(negedge clk);
        idle();
        #1;
        check("R7 flag low when idle", DW'(conflict), '0);
    endtask

    // Sweep all registers through all three read ports.
    task automatic verify_all(input string req);
        for (int r = 0; r < 32; r++) begin
            rd_addr[r % NR] = 5'(r);
            #1;
            check(req, rd_data[r % NR], model[r]);
        end
    endtask

    task automatic t_reset();
        apply_reset();
        verify_all("R9 reset clears");
    endtask

    task automatic t_port0();
        for (int i = 0; i < 16; i++) do_write(1'b1, {1'b0, 4'(i)}, pat(i, 1), 1'b0, '0, '0);
        verify_all("R3 bank A writes");
        do_write(1'b1, 5'd21, pat(99, 2), 1'b0, '0, '0);
        verify_all("R3 port0 stays in bank A");
    endtask

    task automatic t_port1();
        for (int i = 0; i < 16; i++) do_write(1'b0, '0, '0, 1'b1, {1'b1, 4'(i)}, pat(i, 3));
        verify_all("R4 bank B writes");
        do_write(1'b0, '0, '0, 1'b1, 5'd7, pat(77, 4));
        verify_all("R4 port1 stays in bank B");
    endtask

    task automatic t_dual();
        do_write(1'b1, 5'd3, pat(3, 5), 1'b1, 5'd19, pat(19, 5));
        do_write(1'b1, 5'd12, pat(12, 6), 1'b1, 5'd30, pat(30, 6));
        verify_all("R5 dual write");
    endtask

    task automatic t_reads();
        @(negedge clk);
        rd_addr[0] = 5'd2; rd_addr[1] = 5'd18; rd_addr[2] = 5'd2;
        #1;
        check("R2 port0", rd_data[0], model[2]);
        check("R2 port1", rd_data[1], model[18]);
        check("R2 port2 same reg", rd_data[2], model[2]);
        check("R1 bank split", DW'(rd_data[0] != rd_data[1]), DW'(1));
    endtask

    task automatic t_rbw();
        logic [DW-1:0] old9;
        logic [DW-1:0] old25;
        old9  = model[9];
        old25 = model[25];
        @(negedge clk);
        wr_en0 = 1'b1; wr_addr0 = 5'd9;  wr_data0 = pat(9, 7);
        wr_en1 = 1'b1; wr_addr1 = 5'd25; wr_data1 = pat(25, 7);
        rd_addr[0] = 5'd9; rd_addr[1] = 5'd25; rd_addr[2] = 5'd9;
        #1;
        check("R6 old value A", rd_data[0], old9);
        check("R6 old value B", rd_data[1], old25);
        @(posedge clk);
        model[9]  = pat(9, 7);
        model[25] = pat(25, 7);
        @(negedge clk);
        idle();
        #1;
        check("R6 new value A", rd_data[2], pat(9, 7));
        check("R6 new value B", rd_data[1], pat(25, 7));
    endtask

    task automatic t_conflict();
        do_write(1'b1, 5'd4, pat(4, 8), 1'b1, 5'd6, pat(6, 8));
        verify_all("R8 conflict in bank A");
        do_write(1'b1, 5'd24, pat(24, 9), 1'b1, 5'd24, pat(88, 9));
        verify_all("R8 conflict in bank B");
        do_write(1'b0, 5'd1, pat(1, 10), 1'b1, 5'd1, pat(2, 10));
        verify_all("R10 single write leaves others");
    endtask

    initial begin
        rst_n = 1'b1;
        idle();
        wr_addr0 = '0; wr_data0 = '0; wr_addr1 = '0; wr_data1 = '0;
        rd_addr = '0;
        t_reset();
        t_port0();
        t_port1();
        t_dual();
        t_reads();
        t_rbw();
        t_conflict();
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule